// File: doc/BRIEF.md
# Split-Transaction Bus Master Sequencer

This block sits between one processor's cache and a split-transaction system bus. The cache posts shared-read, exclusive-read and writeback messages into an outbound queue. When the arbiter grants the bus, the sequencer reserves a bus tag from a small free pool and drives the head message onto the address bus. In the next cycle the snoop responses of all other caches are folded into one verdict: unanimous-ok or retry.

On unanimous-ok a read is moved into an in-order outstanding queue together with its tag and target state. A writeback is complete at that point, because its payload travels with the address. On retry the message is rotated to the tail of the outbound queue, so other queued messages go first. Tagged data cycles are matched against the oldest outstanding read. A match raises a fill towards the cache with the line address, the recorded state and the data, and frees the tag.

Top module: `stq_bus_master`

## Requirements
- R1: After synchronous reset both queues are empty and all tags are free. `req_ready` is 1, and `addr_valid`, `resp_valid` and `fill_valid` are 0.
- R2: When `bus_grant` is high, no response is pending, the outbound queue is not empty and a tag is free, `addr_valid` is high in that same cycle. The address bus then carries the head message's kind, address and data, together with the lowest-numbered free tag. Kind encoding: 0 = shared read, 1 = exclusive read, 2 = writeback.
- R3: `resp_valid` is high exactly in the cycle after an issue. In that cycle `resp_uok` is 1 only if every bit of `snp_ok` is 1, and is 0 otherwise (retry).
- R4: A read that receives unanimous-ok leaves the outbound queue and is recorded with its tag, its address and exclusive flag (1 for kind 1).
- R5: A retried message leaves the head and re-enters at the tail with the same kind and address. Its tag returns to the pool.
- R6: When `dbus_valid` is high and `dbus_tag` equals the tag of the oldest outstanding read, `fill_valid` is high in that same cycle. `fill_addr` and `fill_excl` carry the recorded address and state, `fill_data` carries `dbus_data`, and the entry is removed.
- R7: A writeback with unanimous-ok leaves the queue, creates no outstanding entry and frees its tag at once. Its payload is driven on `addr_data` during the issue cycle.
- R8: Up to four reads may be outstanding at once, each with a distinct tag.
- R9: While all four tags are in use, no message is issued, even when the bus is granted.
- R10: A data cycle whose tag does not match the oldest outstanding read produces no fill and leaves the outstanding queue unchanged.
- R11: `req_ready` is 0 while the outbound queue is full or a response is pending. No second issue takes place in a response cycle.
- R12: A tag freed by a completed fill can be assigned to a new issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cache posts a message |
| req_kind | input | 2 | Message kind (0 shared, 1 exclusive, 2 writeback) |
| req_addr | input | 16 | Line address |
| req_data | input | 16 | Writeback payload |
| req_ready | output | 1 | Outbound queue accepts a message |
| bus_grant | input | 1 | Arbiter grants the address bus |
| addr_valid | output | 1 | Address phase active |
| addr_tag | output | 2 | Bus tag of the issued message |
| addr_kind | output | 2 | Kind of the issued message |
| addr_addr | output | 16 | Address of the issued message |
| addr_data | output | 16 | Writeback payload of the issued message |
| snp_ok | input | NSNP | One ok bit per snooper, sampled in the response cycle |
| resp_valid | output | 1 | Response phase active |
| resp_uok | output | 1 | Combined verdict: 1 unanimous-ok, 0 retry |
| dbus_valid | input | 1 | Data cycle on the bus |
| dbus_tag | input | 2 | Tag of the data cycle |
| dbus_data | input | 16 | Data of the data cycle |
| fill_valid | output | 1 | Install a line in the cache |
| fill_addr | output | 16 | Line address to install |
| fill_excl | output | 1 | 1 installs exclusive, 0 installs shared |
| fill_data | output | 16 | Line data to install |

## Verification
The bench sweeps every snoop-response pattern. If the combiner took a majority or any-ok instead of requiring every ok, some pattern would yield a wrong verdict. It fills the tag pool and then grants the bus. A design that ignored tag exhaustion would issue with a tag that is still in use. It sends a data cycle for a younger tag ahead of the oldest one, which exposes a design that matches any outstanding entry or pops on the wrong tag. It retries a message with another queued behind it: a design that reissued the same message at once, or kept its tag, would show the wrong order or the wrong tag. A writeback followed by a read shows whether a writeback leaks an outstanding entry or keeps its tag.

// File: rtl/stq_pkg.sv
package stq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int TAGS_N = 4;
    localparam int TAG_W  = $clog2(TAGS_N);

    typedef enum logic [1:0] {
        K_SHARED = 2'b00,
        K_EXCL   = 2'b01,
        K_WBACK  = 2'b10
    } req_kind_e;

    typedef struct packed {
        req_kind_e          kind;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
    } out_req_t;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic               excl;
        logic [ADDR_W-1:0]  addr;
    } pend_rd_t;

    function automatic logic kind_is_read(req_kind_e k);
        return (k == K_SHARED) || (k == K_EXCL);
    endfunction

endpackage

// File: rtl/stq_fifo.sv
module stq_fifo #(
    parameter type ENT_T = logic [7:0],
    parameter int  DEPTH = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  ENT_T          push_ent,
    input  logic          pop,
    output ENT_T          head,
    output logic          nempty,
    output logic          full,
    output logic [CW-1:0] count
);

    ENT_T          mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_ent;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head   = mem[rd_ptr];
    assign nempty = (count != '0);
    assign full   = (count == CW'(DEPTH));

endmodule

// File: rtl/stq_tag_pool.sv
module stq_tag_pool #(
    parameter int  NTAGS = 4,
    localparam int TW    = $clog2(NTAGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             rel_a,
    input  logic [TW-1:0]    rel_a_tag,
    input  logic             rel_b,
    input  logic [TW-1:0]    rel_b_tag,
    output logic             any_free,
    output logic [TW-1:0]    free_tag,
    output logic [NTAGS-1:0] busy
);

    always_comb begin
        free_tag = '0;
        for (int i = NTAGS - 1; i >= 0; i--) begin
            if (!busy[i]) free_tag = TW'(i);
        end
    end

    assign any_free = !(&busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
        end else begin
            for (int i = 0; i < NTAGS; i++) begin
                if (alloc && any_free && free_tag == TW'(i))
                    busy[i] <= 1'b1;
                else if ((rel_a && rel_a_tag == TW'(i)) ||
                         (rel_b && rel_b_tag == TW'(i)))
                    busy[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/stq_snoop_combine.sv
module stq_snoop_combine #(
    parameter int NSNP = 3
) (
    input  logic            phase,
    input  logic [NSNP-1:0] ok_vec,
    output logic            uok,
    output logic            retry
);

    logic [NSNP:0] chain;

    assign chain[0] = 1'b1;
    for (genvar g = 0; g < NSNP; g++) begin : g_and
        assign chain[g+1] = chain[g] & ok_vec[g];
    end

    assign uok   = phase & chain[NSNP];
    assign retry = phase & ~chain[NSNP];

endmodule

// File: rtl/stq_bus_master.sv
module stq_bus_master
    import stq_pkg::*;
#(
    parameter int  OQ_DEPTH = 4,
    parameter int  NSNP     = 3,
    localparam int QCW      = $clog2(OQ_DEPTH + 1),
    localparam int BCW      = $clog2(TAGS_N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    input  logic              bus_grant,
    output logic              addr_valid,
    output logic [TAG_W-1:0]  addr_tag,
    output logic [1:0]        addr_kind,
    output logic [ADDR_W-1:0] addr_addr,
    output logic [DATA_W-1:0] addr_data,
    input  logic [NSNP-1:0]   snp_ok,
    output logic              resp_valid,
    output logic              resp_uok,
    input  logic              dbus_valid,
    input  logic [TAG_W-1:0]  dbus_tag,
    input  logic [DATA_W-1:0] dbus_data,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              fill_excl,
    output logic [DATA_W-1:0] fill_data
);

    // outbound queue
    out_req_t          oq_head;
    out_req_t          oq_in;
    logic              oq_push;
    logic              oq_pop;
    logic              oq_nempty;
    logic              oq_full;
    logic [QCW-1:0]    q_count;

    // outstanding read queue
    pend_rd_t          obt_head;
    pend_rd_t          obt_in;
    logic              obt_push;
    logic              obt_pop;
    logic              obt_nempty;
    logic              obt_full;
    logic [BCW-1:0]    obt_count;

    // tags and phase state
    logic              tag_any_free;
    logic [TAG_W-1:0]  tag_next;
    logic [TAGS_N-1:0] tag_busy;
    logic              pend;
    logic [TAG_W-1:0]  pend_tag;
    logic              issue;
    logic              rsp_ok;
    logic              rsp_retry;
    logic              head_rd;
    logic              rel_rsp;
    logic              hit;

    assign issue   = bus_grant && !pend && oq_nempty && tag_any_free;
    assign head_rd = kind_is_read(oq_head.kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            pend_tag <= '0;
        end else begin
            pend <= issue;
            if (issue) pend_tag <= tag_next;
        end
    end

    stq_snoop_combine #(.NSNP(NSNP)) u_comb (
        .phase  (pend),
        .ok_vec (snp_ok),
        .uok    (rsp_ok),
        .retry  (rsp_retry)
    );

    // outbound queue control: a retry rotates the head to the tail
    assign req_ready = !oq_full && !pend;
    assign oq_pop    = pend;
    assign oq_push   = rsp_retry || (req_valid && req_ready);

    always_comb begin
        if (rsp_retry) begin
            oq_in = oq_head;
        end else begin
            oq_in.kind = req_kind_e'(req_kind);
            oq_in.addr = req_addr;
            oq_in.data = req_data;
        end
    end

    stq_fifo #(.ENT_T(out_req_t), .DEPTH(OQ_DEPTH)) u_oq (
        .clk      (clk),
        .rst      (rst),
        .push     (oq_push),
        .push_ent (oq_in),
        .pop      (oq_pop),
        .head     (oq_head),
        .nempty   (oq_nempty),
        .full     (oq_full),
        .count    (q_count)
    );

    // accepted reads wait for their data cycle in issue order
    assign obt_push    = rsp_ok && head_rd;
    assign obt_in.tag  = pend_tag;
    assign obt_in.excl = (oq_head.kind == K_EXCL);
    assign obt_in.addr = oq_head.addr;

    assign hit     = dbus_valid && obt_nempty && (dbus_tag == obt_head.tag);
    assign obt_pop = hit;

    stq_fifo #(.ENT_T(pend_rd_t), .DEPTH(TAGS_N)) u_obt (
        .clk      (clk),
        .rst      (rst),
        .push     (obt_push),
        .push_ent (obt_in),
        .pop      (obt_pop),
        .head     (obt_head),
        .nempty   (obt_nempty),
        .full     (obt_full),
        .count    (obt_count)
    );

    // tag returns: at a retry or writeback verdict, and at a fill
    assign rel_rsp = rsp_retry || (rsp_ok && !head_rd);

    stq_tag_pool #(.NTAGS(TAGS_N)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .alloc     (issue),
        .rel_a     (rel_rsp),
        .rel_a_tag (pend_tag),
        .rel_b     (hit),
        .rel_b_tag (obt_head.tag),
        .any_free  (tag_any_free),
        .free_tag  (tag_next),
        .busy      (tag_busy)
    );

    assign addr_valid = issue;
    assign addr_tag   = tag_next;
    assign addr_kind  = oq_head.kind;
    assign addr_addr  = oq_head.addr;
    assign addr_data  = oq_head.data;

    assign resp_valid = pend;
    assign resp_uok   = rsp_ok;

    assign fill_valid = hit;
    assign fill_addr  = obt_head.addr;
    assign fill_excl  = obt_head.excl;
    assign fill_data  = dbus_data;

endmodule

// File: rtl/stq_bus_master_chk.sv
module stq_bus_master_chk
    import stq_pkg::*;
#(
    parameter int  OQ_DEPTH = 4,
    parameter int  NSNP     = 3,
    localparam int QCW      = $clog2(OQ_DEPTH + 1),
    localparam int BCW      = $clog2(TAGS_N + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_grant,
    input logic              addr_valid,
    input logic              req_ready,
    input logic [NSNP-1:0]   snp_ok,
    input logic              resp_valid,
    input logic              resp_uok,
    input logic              dbus_valid,
    input logic              fill_valid,
    input logic [QCW-1:0]    q_count,
    input logic [BCW-1:0]    obt_count,
    input logic [TAGS_N-1:0] tag_busy
);

    p_issue_needs_grant_r2: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> bus_grant);

    p_no_back_to_back_r11: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> (!addr_valid && !req_ready));

    p_resp_follows_issue_r3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(addr_valid));

    p_retry_on_any_nack_r3: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !(&snp_ok)) |-> !resp_uok);

    p_retry_keeps_depth_r5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_uok) |=> (q_count == $past(q_count)));

    p_fill_needs_data_r6: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> dbus_valid);

    p_tag_per_entry_r8: assert property (@(posedge clk) disable iff (rst)
        int'(obt_count) <= $countones(tag_busy));

    p_no_issue_pool_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (&tag_busy) |-> !addr_valid);

endmodule

bind stq_bus_master stq_bus_master_chk #(.OQ_DEPTH(OQ_DEPTH), .NSNP(NSNP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_grant  (bus_grant),
    .addr_valid (addr_valid),
    .req_ready  (req_ready),
    .snp_ok     (snp_ok),
    .resp_valid (resp_valid),
    .resp_uok   (resp_uok),
    .dbus_valid (dbus_valid),
    .fill_valid (fill_valid),
    .q_count    (q_count),
    .obt_count  (obt_count),
    .tag_busy   (tag_busy)
);

// File: tb/test_stq_bus_master.sv
`timescale 1ns/1ps
module test_stq_bus_master;
    import stq_pkg::*;

    localparam int NSNP = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              req_ready;
    logic              bus_grant = 1'b0;
    logic              addr_valid;
    logic [TAG_W-1:0]  addr_tag;
    logic [1:0]        addr_kind;
    logic [ADDR_W-1:0] addr_addr;
    logic [DATA_W-1:0] addr_data;
    logic [NSNP-1:0]   snp_ok = '1;
    logic              resp_valid;
    logic              resp_uok;
    logic              dbus_valid = 1'b0;
    logic [TAG_W-1:0]  dbus_tag = '0;
    logic [DATA_W-1:0] dbus_data = '0;
    logic              fill_valid;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_excl;
    logic [DATA_W-1:0] fill_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    stq_bus_master #(.OQ_DEPTH(4), .NSNP(NSNP)) i_stq_bus_master (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_data(req_data), .req_ready(req_ready),
        .bus_grant(bus_grant), .addr_valid(addr_valid), .addr_tag(addr_tag),
        .addr_kind(addr_kind), .addr_addr(addr_addr), .addr_data(addr_data),
        .snp_ok(snp_ok), .resp_valid(resp_valid), .resp_uok(resp_uok),
        .dbus_valid(dbus_valid), .dbus_tag(dbus_tag), .dbus_data(dbus_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_excl(fill_excl),
        .fill_data(fill_data)
    );

    task automatic chk(input bit cond, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic enq(input logic [1:0] k, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_data = d;
        #1;
        chk(req_ready == 1'b1, "R11", "req_ready on enqueue", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // grant, check address phase, then apply snoop pattern in response cycle
    task automatic issue(input logic [NSNP-1:0] okv, input logic [1:0] ek,
                         input logic [15:0] ea, input logic [15:0] ed,
                         input logic [1:0] et, input string rq);
        @(negedge clk);
        bus_grant = 1'b1;
        #1;
        chk(addr_valid == 1'b1, rq, "addr_valid", addr_valid, 1);
        chk(addr_kind == ek, rq, "addr_kind", addr_kind, ek);
        chk(addr_addr == ea, rq, "addr_addr", addr_addr, ea);
        chk(addr_tag == et, rq, "addr_tag", addr_tag, et);
        if (ek == 2'd2) chk(addr_data == ed, "R7", "addr_data", addr_data, ed);
        @(posedge clk);
        @(negedge clk);
        snp_ok = okv;
        #1;
        chk(resp_valid == 1'b1, "R3", "resp_valid", resp_valid, 1);
        chk(resp_uok == (&okv), "R3", "resp_uok", resp_uok, int'(&okv));
        chk(addr_valid == 1'b0, "R11", "issue in response cycle", addr_valid, 0);
        chk(req_ready == 1'b0, "R11", "req_ready while pending", req_ready, 0);
        @(posedge clk);
        @(negedge clk);
        bus_grant = 1'b0;
        snp_ok = '1;
    endtask

    task automatic data_cyc(input logic [1:0] t, input logic [15:0] d,
                            input bit ef, input logic [15:0] ea, input bit ex,
                            input string rq);
        @(negedge clk);
        dbus_valid = 1'b1; dbus_tag = t; dbus_data = d;
        #1;
        chk(fill_valid == ef, rq, "fill_valid", fill_valid, ef);
        if (ef) begin
            chk(fill_addr == ea, rq, "fill_addr", fill_addr, ea);
            chk(fill_excl == ex, rq, "fill_excl", fill_excl, ex);
            chk(fill_data == d, rq, "fill_data", fill_data, d);
        end
        @(posedge clk);
        @(negedge clk);
        dbus_valid = 1'b0;
    endtask

    task automatic no_issue(input string rq);
        @(negedge clk);
        bus_grant = 1'b1;
        #1;
        chk(addr_valid == 1'b0, rq, "addr_valid with grant", addr_valid, 0);
        @(posedge clk);
        @(negedge clk);
        bus_grant = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0]  cur_k;
        logic [15:0] cur_a;
        bit          have;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bus_grant = 1'b1;
        dbus_valid = 1'b1; dbus_tag = '0;
        #1;
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(addr_valid == 1'b0, "R1", "addr_valid", addr_valid, 0);
        chk(resp_valid == 1'b0, "R1", "resp_valid", resp_valid, 0);
        chk(fill_valid == 1'b0, "R1", "fill_valid", fill_valid, 0);
        @(posedge clk);
        @(negedge clk);
        bus_grant = 1'b0; dbus_valid = 1'b0;

        // R3 sweep over every snoop pattern; R4 fill on each accepted read
        have = 1'b0; cur_k = 2'd0; cur_a = '0;
        for (int p = 0; p < (1 << NSNP); p++) begin
            if (!have) begin
                cur_k = 2'(p & 1);
                cur_a = 16'h0100 + 16'(p);
                enq(cur_k, cur_a, 16'h0);
                have = 1'b1;
            end
            issue(NSNP'(p), cur_k, cur_a, 16'h0, 2'd0, "R2");
            if (p == (1 << NSNP) - 1) begin
                data_cyc(2'd0, cur_a ^ 16'h5A5A, 1'b1, cur_a, cur_k[0], "R4");
                have = 1'b0;
            end
        end

        // R8/R9/R10/R12: four reads in flight
        for (int i = 0; i < 4; i++) enq(2'(i & 1), 16'h0200 + 16'(i), 16'h0);
        @(negedge clk);
        #1;
        chk(req_ready == 1'b0, "R11", "req_ready when full", req_ready, 0);
        for (int i = 0; i < 4; i++)
            issue('1, 2'(i & 1), 16'h0200 + 16'(i), 16'h0, 2'(i), "R8");
        enq(2'd0, 16'h02AA, 16'h0);
        no_issue("R9");
        data_cyc(2'd2, 16'h1111, 1'b0, 16'h0, 1'b0, "R10");
        data_cyc(2'd0, 16'h2222, 1'b1, 16'h0200, 1'b0, "R6");
        issue('1, 2'd0, 16'h02AA, 16'h0, 2'd0, "R12");
        data_cyc(2'd1, 16'h3333, 1'b1, 16'h0201, 1'b1, "R6");
        data_cyc(2'd2, 16'h4444, 1'b1, 16'h0202, 1'b0, "R10");
        data_cyc(2'd3, 16'h5555, 1'b1, 16'h0203, 1'b1, "R6");
        data_cyc(2'd0, 16'h6666, 1'b1, 16'h02AA, 1'b0, "R12");

        // R5: retry rotates head behind the next message
        enq(2'd0, 16'h0300, 16'h0);
        enq(2'd1, 16'h0301, 16'h0);
        issue(3'b101, 2'd0, 16'h0300, 16'h0, 2'd0, "R5");
        issue('1, 2'd1, 16'h0301, 16'h0, 2'd0, "R5");
        issue('1, 2'd0, 16'h0300, 16'h0, 2'd1, "R5");
        data_cyc(2'd0, 16'h7777, 1'b1, 16'h0301, 1'b1, "R5");
        data_cyc(2'd1, 16'h8888, 1'b1, 16'h0300, 1'b0, "R5");

        // R7: writeback leaves no outstanding entry and frees its tag
        enq(2'd2, 16'h0400, 16'hBEEF);
        issue('1, 2'd2, 16'h0400, 16'hBEEF, 2'd0, "R7");
        data_cyc(2'd0, 16'h9999, 1'b0, 16'h0, 1'b0, "R7");
        enq(2'd0, 16'h0401, 16'h0);
        issue('1, 2'd0, 16'h0401, 16'h0, 2'd0, "R7");
        data_cyc(2'd0, 16'hAAAA, 1'b1, 16'h0401, 1'b0, "R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule